// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block holds the list registers that a hypervisor fills in to describe virtual interrupts. Each virtual CPU has its own small bank of 32-bit entries. An entry carries a virtual interrupt number, a linked physical number, a 5-bit priority, a two-bit life-cycle state, a group flag and a flag that marks it as backed by a real hardware interrupt. The hypervisor writes whole entries through a simple write port and reads them back through a read port.

The virtual CPU interface sends commands against one virtual CPU and one virtual interrupt number. There are four commands: look up, acknowledge, check an end-of-interrupt, and deactivate. Each command searches the bank for the lowest-numbered live entry with that number. It answers one cycle later with hit or error, the entry's group and its priority scaled to 8 bits. Acknowledge and deactivate also update the entry's state. When a hardware-backed entry is deactivated, the block can send a deactivate request for the linked physical interrupt to the physical distributor. That request is filtered by interrupt range and by group when security is on, and it names either one real CPU or all of them.

Top module: `vlr_bank`

## Requirements
- R1: An entry is a 32-bit word: bit 31 hardware flag, bit 30 group-1 flag, bits 29:28 state, bits 27:23 priority, bits 19:10 physical ID (its low 3 bits also serve as a source CPU field and bit 19 as an EOI flag), bits 9:0 virtual ID. A write stores the word unchanged and the read port returns it in the same cycle. After reset every entry reads 0.
- R2: The state codes are 0 invalid, 1 pending, 2 active, 3 active-and-pending. A lookup selects the lowest-indexed entry whose virtual ID matches the command and whose state is not 0, even when several entries match.
- R3: On every command the response carries the selected entry's group-1 flag and its priority shifted left by 3 (low 3 bits zero). With no selected entry both are 0.
- R4: Acknowledge (op 1) on a selected entry clears state bit 0 and sets state bit 1.
- R5: End-of-interrupt check (op 2) hits when any entry of that virtual CPU with a matching virtual ID has state bit 1 set, and flags an error otherwise. It changes no state.
- R6: Deactivate (op 3) needs the same condition as R5. When it holds, state bit 1 of the selected entry (R2) is cleared. When it does not hold, an error is flagged and nothing changes.
- R7: Lookup (op 0) and acknowledge with no selected entry flag an error and change no state. Every response has exactly one of hit and error set.
- R8: A valid deactivate of an entry with the hardware flag set forwards a physical deactivate. The forward is suppressed when the physical ID is below 16 or at or above MAX_IRQ.
- R9: With security enabled, the forward is dropped unless the distributor reports the physical interrupt as group 1 for the real CPU.
- R10: The forwarded CPU mask is the real CPU's bit alone when the physical ID is below 32, and all CPUs otherwise.
- R11: Command CPU index c selects virtual CPU c - NCPU, which is also the real CPU number. An index below NCPU, or at or above NCPU+NVCPU, gives an error and no update.
- R12: Responses and forwards appear exactly one cycle after the command, and they are all zero in cycles without a command. A hypervisor write to the same entry in the same cycle as a state update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Hypervisor entry write strobe |
| wr_vcpu | input | 1 | Virtual CPU bank to write |
| wr_idx | input | 2 | Entry index to write |
| wr_data | input | 32 | Entry word to write |
| rd_vcpu | input | 1 | Virtual CPU bank to read |
| rd_idx | input | 2 | Entry index to read |
| rd_data | output | 32 | Entry word read, combinational |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 lookup, 1 acknowledge, 2 EOI check, 3 deactivate |
| cmd_cpu | input | 2 | CPU index of the command (virtual when >= NCPU) |
| cmd_virq | input | 10 | Virtual interrupt ID searched |
| sec_ext | input | 1 | Security extensions enabled |
| grpq_id | output | 10 | Physical ID whose group is queried from the distributor |
| grpq_cpu | output | 1 | Real CPU for the group query |
| grpq_g1 | input | 1 | Distributor answer: queried interrupt is group 1 |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Command succeeded |
| rsp_err | output | 1 | Command missed or invalid |
| rsp_grp1 | output | 1 | Group-1 flag of selected entry |
| rsp_prio | output | 8 | Scaled priority of selected entry |
| pd_valid | output | 1 | Physical deactivate request |
| pd_id | output | 10 | Physical interrupt to deactivate |
| pd_mask | output | 2 | Real CPUs the deactivate applies to |

## Verification
The lookup is tried with duplicate virtual IDs where the lower entry is live and where it is invalid. This separates first-match selection from any-match and from last-match. Acknowledge is applied to pending and to active-and-pending entries, and deactivate to entries with and without a competing lower-indexed pending duplicate. This shows whether the update lands on the selected entry and touches only the intended state bit. Physical forwards are driven at IDs 10, 20, 50, 95 and 96, with security on and off and both group answers, from both virtual CPUs. Together these cover each range edge, the group filter and the single-CPU versus broadcast mask. Real-CPU indices and a same-cycle write on an entry being updated check the CPU mapping and the write-priority rule.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

    localparam int VID_W        = 10;
    localparam int SGI_LIMIT    = 16;
    localparam int PRIV_LIMIT   = 32;

    typedef enum logic [1:0] {
        ST_INVALID  = 2'd0,
        ST_PENDING  = 2'd1,
        ST_ACTIVE   = 2'd2,
        ST_ACT_PEND = 2'd3
    } vlr_state_e;

    typedef enum logic [1:0] {
        OP_LOOKUP    = 2'd0,
        OP_ACK       = 2'd1,
        OP_EOI_CHECK = 2'd2,
        OP_DEACT     = 2'd3
    } vlr_op_e;

    typedef struct packed {
        logic                 hw;
        logic                 grp1;
        vlr_state_e           state;
        logic [4:0]           prio;
        logic [2:0]           spare;
        logic [VID_W-1:0]     pid;
        logic [VID_W-1:0]     vid;
    } vlr_entry_t;

    function automatic logic entry_live(vlr_entry_t e);
        return e.state != ST_INVALID;
    endfunction

    function automatic logic entry_active(vlr_entry_t e);
        return (e.state == ST_ACTIVE) || (e.state == ST_ACT_PEND);
    endfunction

    function automatic vlr_state_e state_after_ack(vlr_state_e s);
        return vlr_state_e'((s & 2'b10) | 2'b10);
    endfunction

    function automatic vlr_state_e state_after_deact(vlr_state_e s);
        return vlr_state_e'(s & 2'b01);
    endfunction

    function automatic logic [7:0] prio_scaled(logic [4:0] p);
        return {p, 3'b000};
    endfunction

endpackage

// File: rtl/vlr_match.sv
module vlr_match
    import vlr_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int LRW    = 2
) (
    input  vlr_entry_t [NUM_LR-1:0] ents,
    input  logic [VID_W-1:0]        virq,
    output logic                    hit,
    output logic [LRW-1:0]          hit_idx,
    output logic                    act_any
);

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        act_any = 1'b0;
        // scan downward so the lowest index is the one that remains
        for (int i = NUM_LR - 1; i >= 0; i--) begin
            if (ents[i].vid == virq && entry_live(ents[i])) begin
                hit     = 1'b1;
                hit_idx = LRW'(i);
            end
            if (ents[i].vid == virq && entry_active(ents[i])) begin
                act_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vlr_fwd.sv
module vlr_fwd
    import vlr_pkg::*;
#(
    parameter int NCPU    = 2,
    parameter int NW      = 1,
    parameter int MAX_IRQ = 96
) (
    input  logic              en,
    input  logic [VID_W-1:0]  pid,
    input  logic [NW-1:0]     rcpu,
    input  logic              sec_ext,
    input  logic              grp1,
    output logic              go,
    output logic [NCPU-1:0]   mask
);

    logic in_range;
    logic allowed;
    logic is_private;

    assign in_range   = (32'(pid) >= SGI_LIMIT) && (32'(pid) < MAX_IRQ);
    assign allowed    = !sec_ext || grp1;
    assign is_private = 32'(pid) < PRIV_LIMIT;
    assign go         = en && in_range && allowed;

    for (genvar c = 0; c < NCPU; c++) begin : g_mask
        assign mask[c] = is_private ? (32'(rcpu) == c) : 1'b1;
    end

endmodule

// File: rtl/vlr_bank.sv
module vlr_bank
    import vlr_pkg::*;
#(
    parameter int NCPU    = 2,
    parameter int NVCPU   = 2,
    parameter int NUM_LR  = 4,
    parameter int MAX_IRQ = 96,
    localparam int LRW    = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
    localparam int VW     = (NVCPU > 1) ? $clog2(NVCPU) : 1,
    localparam int NW     = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int CPUW   = $clog2(NCPU + NVCPU)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [VW-1:0]     wr_vcpu,
    input  logic [LRW-1:0]    wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [VW-1:0]     rd_vcpu,
    input  logic [LRW-1:0]    rd_idx,
    output logic [31:0]       rd_data,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CPUW-1:0]   cmd_cpu,
    input  logic [VID_W-1:0]  cmd_virq,
    input  logic              sec_ext,
    output logic [VID_W-1:0]  grpq_id,
    output logic [NW-1:0]     grpq_cpu,
    input  logic              grpq_g1,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic              rsp_grp1,
    output logic [7:0]        rsp_prio,
    output logic              pd_valid,
    output logic [VID_W-1:0]  pd_id,
    output logic [NCPU-1:0]   pd_mask
);

    vlr_entry_t lr_q [NVCPU][NUM_LR];

    // command CPU decode: virtual index relative to the real CPU count
    logic [CPUW-1:0] vrel;
    logic            cmd_ok;
    logic [VW-1:0]   vsel;
    logic [NW-1:0]   rcpu;

    assign vrel   = cmd_cpu - CPUW'(NCPU);
    assign cmd_ok = (cmd_cpu >= CPUW'(NCPU)) && (vrel < CPUW'(NVCPU));
    assign vsel   = vrel[VW-1:0];
    assign rcpu   = vrel[NW-1:0];

    vlr_entry_t [NUM_LR-1:0] sel_bank;

    always_comb begin
        for (int i = 0; i < NUM_LR; i++) begin
            sel_bank[i] = cmd_ok ? lr_q[vsel][i] : '0;
        end
    end

    logic            m_hit;
    logic [LRW-1:0]  m_idx;
    logic            m_act;
    vlr_entry_t      m_ent;

    vlr_match #(.NUM_LR(NUM_LR), .LRW(LRW)) u_match (
        .ents    (sel_bank),
        .virq    (cmd_virq),
        .hit     (m_hit),
        .hit_idx (m_idx),
        .act_any (m_act)
    );

    assign m_ent = sel_bank[m_idx];

    vlr_op_e op;
    logic    sel_ok;
    logic    cmd_good;

    assign op       = vlr_op_e'(cmd_op);
    assign sel_ok   = cmd_ok && m_hit;
    assign cmd_good = ((op == OP_EOI_CHECK) || (op == OP_DEACT)) ? (cmd_ok && m_act) : sel_ok;

    logic            fwd_go;
    logic [NCPU-1:0] fwd_mask;

    assign grpq_id  = m_ent.pid;
    assign grpq_cpu = rcpu;

    vlr_fwd #(.NCPU(NCPU), .NW(NW), .MAX_IRQ(MAX_IRQ)) u_fwd (
        .en      (cmd_valid && cmd_good && (op == OP_DEACT) && m_ent.hw),
        .pid     (m_ent.pid),
        .rcpu    (rcpu),
        .sec_ext (sec_ext),
        .grp1    (grpq_g1),
        .go      (fwd_go),
        .mask    (fwd_mask)
    );

    assign rd_data = lr_q[rd_vcpu][rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int v = 0; v < NVCPU; v++) begin
                for (int i = 0; i < NUM_LR; i++) begin
                    lr_q[v][i] <= '0;
                end
            end
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_grp1  <= 1'b0;
            rsp_prio  <= '0;
            pd_valid  <= 1'b0;
            pd_id     <= '0;
            pd_mask   <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_hit   <= cmd_valid && cmd_good;
            rsp_err   <= cmd_valid && !cmd_good;
            rsp_grp1  <= cmd_valid && sel_ok && m_ent.grp1;
            rsp_prio  <= (cmd_valid && sel_ok) ? prio_scaled(m_ent.prio) : 8'h00;
            pd_valid  <= fwd_go;
            pd_id     <= fwd_go ? m_ent.pid : '0;
            pd_mask   <= fwd_go ? fwd_mask : '0;
            if (cmd_valid && cmd_good) begin
                if (op == OP_ACK) begin
                    lr_q[vsel][m_idx].state <= state_after_ack(m_ent.state);
                end else if (op == OP_DEACT) begin
                    lr_q[vsel][m_idx].state <= state_after_deact(m_ent.state);
                end
            end
            // hypervisor write is applied last so it wins
            if (wr_en && (32'(wr_vcpu) < NVCPU)) begin
                lr_q[wr_vcpu][wr_idx] <= vlr_entry_t'(wr_data);
            end
        end
    end

    p_hit_xor_err_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit ^ rsp_err));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_err && !pd_valid));

    p_latency_r12: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);

    p_prio_scaled_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_prio[2:0] == 3'b000));

    p_fwd_range_r8: assert property (@(posedge clk) disable iff (rst)
        pd_valid |-> ((32'(pd_id) >= SGI_LIMIT) && (32'(pd_id) < MAX_IRQ)));

    p_fwd_cause_r6: assert property (@(posedge clk) disable iff (rst)
        pd_valid |-> ($past(cmd_valid && cmd_op == 2'd3) && rsp_hit));

    p_fwd_secure_r9: assert property (@(posedge clk) disable iff (rst)
        (pd_valid && $past(sec_ext)) |-> $past(grpq_g1));

    p_mask_private_r10: assert property (@(posedge clk) disable iff (rst)
        (pd_valid && (32'(pd_id) < PRIV_LIMIT)) |-> $onehot(pd_mask));

    p_mask_shared_r10: assert property (@(posedge clk) disable iff (rst)
        (pd_valid && (32'(pd_id) >= PRIV_LIMIT)) |-> (&pd_mask));

    p_real_cpu_err_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_cpu < CPUW'(NCPU))) |=> rsp_err);

endmodule

// File: tb/vlr_bank_test.sv
module vlr_bank_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [0:0]  wr_vcpu;
    logic [1:0]  wr_idx;
    logic [31:0] wr_data;
    logic [0:0]  rd_vcpu;
    logic [1:0]  rd_idx;
    logic [31:0] rd_data;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [1:0]  cmd_cpu;
    logic [9:0]  cmd_virq;
    logic        sec_ext;
    logic [9:0]  grpq_id;
    logic [0:0]  grpq_cpu;
    logic        grpq_g1;
    logic        rsp_valid, rsp_hit, rsp_err, rsp_grp1;
    logic [7:0]  rsp_prio;
    logic        pd_valid;
    logic [9:0]  pd_id;
    logic [1:0]  pd_mask;

    int n_checks = 0;
    int n_bad    = 0;

    logic [31:0] m_lr [2][4];

    always #4 clk = ~clk;

    vlr_bank uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_vcpu(wr_vcpu), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_vcpu(rd_vcpu), .rd_idx(rd_idx), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cpu(cmd_cpu), .cmd_virq(cmd_virq),
        .sec_ext(sec_ext), .grpq_id(grpq_id), .grpq_cpu(grpq_cpu), .grpq_g1(grpq_g1),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
        .rsp_grp1(rsp_grp1), .rsp_prio(rsp_prio),
        .pd_valid(pd_valid), .pd_id(pd_id), .pd_mask(pd_mask)
    );

    function automatic logic [31:0] mk(bit hw, bit g1, int st, int pr, int pid, int vid);
        return {hw, g1, 2'(st), 5'(pr), 3'b000, 10'(pid), 10'(vid)};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // one clock: reference model predicts, then compares at the falling edge
    task automatic step(string tag);
        bit e_valid, e_hit, e_err, e_g1, e_pd;
        logic [7:0] e_prio;
        logic [9:0] e_pid;
        logic [1:0] e_mask;
        int v, first;
        bit cpu_ok, act, ok;
        logic [31:0] e;
        e_valid = cmd_valid; e_hit = 0; e_err = 0; e_g1 = 0; e_prio = 0;
        e_pd = 0; e_pid = 0; e_mask = 0; first = -1; act = 0; v = 0;
        cpu_ok = (cmd_cpu >= 2);
        if (cpu_ok) begin
            v = int'(cmd_cpu) - 2;
            for (int i = 0; i < 4; i++) begin
                if (m_lr[v][i][9:0] == cmd_virq && m_lr[v][i][29:28] != 0 && first < 0) first = i;
                if (m_lr[v][i][9:0] == cmd_virq && m_lr[v][i][29]) act = 1;
            end
        end
        if (cmd_valid) begin
            if (cmd_op == 2 || cmd_op == 3) ok = act;
            else ok = (first >= 0);
            e_hit = ok; e_err = !ok;
            if (first >= 0) begin
                e = m_lr[v][first];
                e_g1 = e[30];
                e_prio = {e[27:23], 3'b000};
                if (cmd_op == 3 && ok && e[31]) begin
                    if (e[19:10] >= 16 && e[19:10] < 96 && (!sec_ext || grpq_g1)) begin
                        e_pd = 1; e_pid = e[19:10];
                        e_mask = (e[19:10] < 32) ? 2'(1 << v) : 2'b11;
                    end
                end
            end
        end else ok = 0;
        @(posedge clk);
        if (ok && cmd_op == 1) m_lr[v][first][29:28] = 2'b10;
        if (ok && cmd_op == 3) m_lr[v][first][29] = 1'b0;
        if (wr_en) m_lr[wr_vcpu][wr_idx] = wr_data;
        @(negedge clk);
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'(e_valid));
        chk(tag, "rsp_hit",   32'(rsp_hit),   32'(e_hit));
        chk(tag, "rsp_err",   32'(rsp_err),   32'(e_err));
        chk(tag, "rsp_grp1",  32'(rsp_grp1),  32'(e_g1));
        chk(tag, "rsp_prio",  32'(rsp_prio),  32'(e_prio));
        chk(tag, "pd_valid",  32'(pd_valid),  32'(e_pd));
        chk(tag, "pd_id",     32'(pd_id),     32'(e_pid));
        chk(tag, "pd_mask",   32'(pd_mask),   32'(e_mask));
    endtask

    task automatic wr(int v, int i, logic [31:0] d);
        wr_en = 1; wr_vcpu = 1'(v); wr_idx = 2'(i); wr_data = d;
        step("R1");
        wr_en = 0;
    endtask

    task automatic cmd(int op, int cpu, int virq, string tag);
        cmd_valid = 1; cmd_op = 2'(op); cmd_cpu = 2'(cpu); cmd_virq = 10'(virq);
        step(tag);
        cmd_valid = 0;
    endtask

    task automatic rd(int v, int i, string tag);
        rd_vcpu = 1'(v); rd_idx = 2'(i);
        #1;
        chk(tag, "rd_data", rd_data, m_lr[v][i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        for (int v = 0; v < 2; v++)
            for (int i = 0; i < 4; i++) m_lr[v][i] = 0;
        rst = 1; wr_en = 0; wr_vcpu = 0; wr_idx = 0; wr_data = 0;
        rd_vcpu = 0; rd_idx = 0; cmd_valid = 0; cmd_op = 0; cmd_cpu = 0;
        cmd_virq = 0; sec_ext = 0; grpq_g1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int v = 0; v < 2; v++)
            for (int i = 0; i < 4; i++) rd(v, i, "R1");
        step("R12");
        cmd(0, 2, 0, "R7");

        // R1 layout and readback, R2 duplicates
        wr(0, 0, mk(0, 1, 1, 5, 0, 40));
        wr(0, 1, mk(0, 0, 2, 9, 0, 40));
        wr(0, 2, mk(0, 1, 0, 3, 0, 41));
        wr(0, 3, mk(0, 0, 3, 31, 7, 50));
        for (int i = 0; i < 4; i++) rd(0, i, "R1");
        cmd(0, 2, 40, "R2");
        cmd(0, 2, 41, "R7");
        cmd(0, 2, 50, "R3");

        // R4 acknowledge
        cmd(1, 2, 40, "R4");
        rd(0, 0, "R4");
        cmd(1, 2, 50, "R4");
        rd(0, 3, "R4");
        cmd(1, 2, 77, "R7");

        // R5 end-of-interrupt check
        wr(0, 2, mk(0, 1, 1, 3, 0, 60));
        cmd(2, 2, 40, "R5");
        cmd(2, 2, 60, "R5");
        rd(0, 2, "R5");

        // R6 deactivate: invalid then valid with lower pending duplicate
        cmd(3, 2, 60, "R6");
        rd(0, 2, "R6");
        wr(0, 0, mk(0, 0, 1, 2, 0, 40));
        cmd(3, 2, 40, "R6");
        rd(0, 0, "R6");
        rd(0, 1, "R6");
        wr(0, 0, mk(0, 0, 2, 2, 0, 40));
        cmd(3, 2, 40, "R6");
        rd(0, 0, "R6");

        // R8 R10 R11 hardware forwards on virtual CPU 1 (real CPU 1)
        for (int k = 0; k < 5; k++) begin
            int pids[5] = '{20, 50, 10, 95, 96};
            wr(1, k % 4, mk(1, 1, 2, 4, pids[k], 70 + k));
            cmd(3, 3, 70 + k, (k < 2) ? "R10" : "R8");
            rd(1, k % 4, "R8");
        end
        // virtual CPU 0 private forward targets real CPU 0
        wr(0, 1, mk(1, 0, 3, 6, 25, 90));
        cmd(3, 2, 90, "R11");
        rd(0, 1, "R11");

        // R9 security filter
        sec_ext = 1; grpq_g1 = 0;
        wr(1, 0, mk(1, 0, 2, 1, 40, 80));
        cmd(3, 3, 80, "R9");
        wr(1, 0, mk(1, 0, 2, 1, 40, 80));
        grpq_g1 = 1;
        cmd(3, 3, 80, "R9");
        sec_ext = 0; grpq_g1 = 0;

        // R11 real CPU indices and per-vcpu isolation
        wr(1, 1, mk(0, 1, 1, 12, 0, 33));
        wr(0, 2, mk(0, 0, 1, 20, 0, 33));
        cmd(0, 0, 33, "R11");
        cmd(1, 1, 33, "R11");
        cmd(0, 3, 33, "R11");
        cmd(0, 2, 33, "R11");

        // R12 same-cycle write wins over acknowledge
        wr_en = 1; wr_vcpu = 1; wr_idx = 1; wr_data = mk(0, 0, 1, 8, 0, 34);
        cmd(1, 3, 33, "R12");
        wr_en = 0;
        rd(1, 1, "R12");
        step("R12");

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule